// File: doc/BRIEF.md
# Indirect Register Window Bridge

The bridge gives software that can only reach a small I/O port range access to a larger memory-mapped register file. It decodes a 32-byte I/O window that holds two 32-bit registers: an offset register and a data port. Software writes a byte offset into the offset register and then reads or writes the data port. Each data-port access is forwarded to the register file at the stored offset, and the access size is passed along unchanged.

The stored offset is forced to a dword boundary inside a 4 KiB target window. Offset bits above that window are dropped, so an out-of-range offset wraps into the window instead of causing a fault. Every other byte of the I/O window reads as zero and ignores writes. A forwarded access completes in one cycle. Every I/O read result is registered and appears on `io_rdata` in the cycle after the read strobe.

Top module: `iow_bridge`

## Requirements
- R1: While reset is asserted and after it is released, the stored offset is 0, `io_rdata` is 0, and neither `rf_rd` nor `rf_wr` is asserted.
- R2: A write at window byte offset 0x10 stores `io_wdata & 0xFFC`: bits above 11 are dropped and bits [1:0] are cleared. Writing 0x13 stores 0x10, writing 0x1234 stores 0x234, and writing 0xFFF stores 0xFFC.
- R3: A read at offset 0x10 returns the stored offset, zero-extended to 32 bits, on `io_rdata` in the cycle after the read strobe.
- R4: A read at offset 0x14 asserts `rf_rd` in the same cycle, with `rf_addr` equal to the stored offset and `rf_size` equal to `io_size`. The `rf_rdata` value of that cycle appears on `io_rdata` in the next cycle.
- R5: A write at offset 0x14 asserts `rf_wr` in the same cycle, with `rf_addr` equal to the stored offset, `rf_size` equal to `io_size`, and `rf_wdata` equal to `io_wdata` bit for bit. The data is little-endian: the lowest-addressed byte is in [7:0]. Size codes are 0 = byte, 1 = halfword, 2 = word.
- R6: A read at any offset other than exactly 0x10 or 0x14, including unaligned offsets such as 0x11, returns 0 and does not assert `rf_rd`.
- R7: A write at any offset other than exactly 0x10 or 0x14 does not assert `rf_wr` and leaves the stored offset unchanged.
- R8: Data-port reads and writes leave the stored offset unchanged. The offset does not auto-increment.
- R9: `io_rdata` keeps its value in every cycle that has no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 5 | Byte offset inside the I/O window |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_size | input | 2 | Access size code (0 byte, 1 half, 2 word) |
| io_wdata | input | 32 | I/O write data, little-endian |
| io_rdata | output | 32 | Registered I/O read data |
| rf_addr | output | 12 | Register-file byte offset |
| rf_rd | output | 1 | Register-file read strobe |
| rf_wr | output | 1 | Register-file write strobe |
| rf_size | output | 2 | Register-file access size |
| rf_wdata | output | 32 | Register-file write data |
| rf_rdata | input | 32 | Register-file read data, valid in the strobe cycle |

## Verification
Some rules are checked by assertions in every cycle:
- Register-file strobes appear only with a matching I/O strobe at the data offset.
- The stored offset changes only on an offset-register write, and then to the masked value.
- `io_rdata` holds between reads.
- A data read captures the register file's value.
- A read of an unused offset yields zero.

The bench scenarios cover what needs concrete values:
- The exact masking examples (0x13, 0x1234, 0xFFF).
- That the size and data pass through unchanged.
- That unaligned offsets count as unused.
- That back-to-back offset and data reads return the right values in order.

// File: rtl/iow_pkg.sv
package iow_pkg;
  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_INDEX = 2'd1,
    SEL_DATA  = 2'd2
  } iow_sel_e;
endpackage

// File: rtl/iow_decode.sv
module iow_decode
  import iow_pkg::*;
#(
  parameter int AW      = 5,
  parameter int IDX_OFF = 16,
  parameter int DAT_OFF = 20
) (
  input  logic [AW-1:0] addr,
  output iow_sel_e      sel
);
  localparam logic [AW-1:0] IDX_A = AW'(IDX_OFF);
  localparam logic [AW-1:0] DAT_A = AW'(DAT_OFF);

  // Exact byte match: unaligned hits on the pair fall to SEL_NONE.
  always_comb begin
    if (addr == IDX_A)      sel = SEL_INDEX;
    else if (addr == DAT_A) sel = SEL_DATA;
    else                    sel = SEL_NONE;
  end
endmodule

// File: rtl/iow_index_reg.sv
module iow_index_reg #(
  parameter int TW    = 12,
  parameter int ALIGN = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] wdata,
  output logic [TW-1:0] idx
);
  localparam logic [TW-1:0] MASK = {{(TW-ALIGN){1'b1}}, {ALIGN{1'b0}}};

  logic [TW-1:0] idx_q, idx_nxt;

  always_comb begin
    idx_nxt = idx_q;
    if (load) idx_nxt = wdata & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_nxt;
  end

  assign idx = idx_q;

  a_r2_masked_store: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (idx == ($past(wdata) & MASK)));
  a_r8_index_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(idx));
endmodule

// File: rtl/iow_rdata_reg.sv
module iow_rdata_reg
  import iow_pkg::*;
#(
  parameter int DW = 32,
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  iow_sel_e      sel,
  input  logic [TW-1:0] idx,
  input  logic [DW-1:0] rf_rdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] src, rdata_q, rdata_nxt;

  always_comb begin
    case (sel)
      SEL_INDEX: src = {{(DW-TW){1'b0}}, idx};
      SEL_DATA:  src = rf_rdata;
      default:   src = '0;
    endcase
  end

  always_comb begin
    rdata_nxt = rdata_q;
    if (rd_en) rdata_nxt = src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_nxt;
  end

  assign rdata = rdata_q;

  a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == SEL_DATA) |=> (rdata == $past(rf_rdata)));
  a_r6_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == SEL_NONE) |=> (rdata == '0));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/iow_bridge.sv
module iow_bridge
  import iow_pkg::*;
#(
  parameter int AW      = 5,
  parameter int DW      = 32,
  parameter int TW      = 12,
  parameter int SW      = 2,
  parameter int IDX_OFF = 16,
  parameter int DAT_OFF = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] io_addr,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic [SW-1:0] io_size,
  input  logic [DW-1:0] io_wdata,
  output logic [DW-1:0] io_rdata,
  output logic [TW-1:0] rf_addr,
  output logic          rf_rd,
  output logic          rf_wr,
  output logic [SW-1:0] rf_size,
  output logic [DW-1:0] rf_wdata,
  input  logic [DW-1:0] rf_rdata
);
  localparam int ALIGN = $clog2(DW / 8);

  iow_sel_e      sel;
  logic          idx_load;
  logic [TW-1:0] idx;

  iow_decode #(.AW(AW), .IDX_OFF(IDX_OFF), .DAT_OFF(DAT_OFF)) u_dec (
    .addr (io_addr),
    .sel  (sel)
  );

  assign idx_load = io_wr && (sel == SEL_INDEX);

  iow_index_reg #(.TW(TW), .ALIGN(ALIGN)) u_idx (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (idx_load),
    .wdata (io_wdata[TW-1:0]),
    .idx   (idx)
  );

  iow_rdata_reg #(.DW(DW), .TW(TW)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (io_rd),
    .sel      (sel),
    .idx      (idx),
    .rf_rdata (rf_rdata),
    .rdata    (io_rdata)
  );

  assign rf_addr  = idx;
  assign rf_rd    = io_rd && (sel == SEL_DATA);
  assign rf_wr    = io_wr && (sel == SEL_DATA);
  assign rf_size  = io_size;
  assign rf_wdata = io_wdata;

  a_r6_rd_gate: assert property (@(posedge clk) disable iff (!rst_n)
    rf_rd |-> (io_rd && io_addr == AW'(DAT_OFF)));
  a_r7_wr_gate: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr |-> (io_wr && io_addr == AW'(DAT_OFF)));
  a_r5_wr_index: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == AW'(DAT_OFF)) |=> $stable(rf_addr));
endmodule

// File: tb/tb_iow_bridge.sv
module tb_iow_bridge;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  io_addr;
  logic        io_wr, io_rd;
  logic [1:0]  io_size;
  logic [31:0] io_wdata, io_rdata;
  logic [11:0] rf_addr;
  logic        rf_rd, rf_wr;
  logic [1:0]  rf_size;
  logic [31:0] rf_wdata, rf_rdata;

  int n_checks = 0;
  int n_errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;
  logic        done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [31:0] pat(input logic [11:0] a);
    return {8'hA5, a, ~a};
  endfunction

  assign rf_rdata = pat(rf_addr);

  iow_bridge dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_size(io_size), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .rf_addr(rf_addr), .rf_rd(rf_rd), .rf_wr(rf_wr), .rf_size(rf_size),
    .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Monitor: one registered result per read strobe, compared against the queue.
  always @(posedge clk) rd_seen <= io_rd && rst_n;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "scoreboard underflow", io_rdata, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(io_rdata === e, t, io_rdata, e);
      end
    end
  end

  // Tasks start at a falling edge and end at the next one.
  task automatic io_read(input logic [4:0] a, input logic [1:0] sz,
                         input logic [31:0] exp, input string tag);
    io_addr = a; io_size = sz; io_rd = 1'b1; io_wr = 1'b0;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    #1;
    if (a == 5'h14) begin
      check(rf_rd === 1'b1, "R4 rf_rd asserted", 32'(rf_rd), 32'h1);
      check(rf_size === sz, "R4 size passthrough", 32'(rf_size), 32'(sz));
    end else begin
      check(rf_rd === 1'b0, "R6 no rf_rd on unused offset", 32'(rf_rd), 32'h0);
    end
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic io_write(input logic [4:0] a, input logic [1:0] sz,
                          input logic [31:0] d, input logic [11:0] cur_idx);
    io_addr = a; io_size = sz; io_wdata = d; io_wr = 1'b1; io_rd = 1'b0;
    #1;
    if (a == 5'h14) begin
      check(rf_wr === 1'b1, "R5 rf_wr asserted", 32'(rf_wr), 32'h1);
      check(rf_addr === cur_idx, "R5 rf_addr is index", 32'(rf_addr), 32'(cur_idx));
      check(rf_wdata === d, "R5 little-endian data passthrough", rf_wdata, d);
      check(rf_size === sz, "R5 size passthrough", 32'(rf_size), 32'(sz));
    end else begin
      check(rf_wr === 1'b0, "R7 no rf_wr", 32'(rf_wr), 32'h0);
    end
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 32'h0, 32'h1);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; io_addr = '0; io_wr = 1'b0; io_rd = 1'b0; io_size = '0; io_wdata = '0;
    repeat (3) @(negedge clk);
    check(io_rdata === 32'h0, "R1 rdata in reset", io_rdata, 32'h0);
    check(rf_rd === 1'b0 && rf_wr === 1'b0, "R1 no strobes in reset",
          {30'h0, rf_rd, rf_wr}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rf_addr === 12'h0, "R1 index zero after reset", 32'(rf_addr), 32'h0);
    io_read(5'h10, 2'd2, 32'h0, "R1 index reads 0");

    io_write(5'h10, 2'd2, 32'h13, 12'h0);
    io_read(5'h10, 2'd2, 32'h10, "R2 R3 0x13 reads back 0x10");
    io_write(5'h10, 2'd2, 32'h1234, 12'h10);
    io_read(5'h10, 2'd2, 32'h234, "R2 0x1234 wraps to 0x234");
    io_write(5'h10, 2'd0, 32'hFFFF_FFFF, 12'h234);
    io_read(5'h10, 2'd2, 32'hFFC, "R2 0xFFF masks to 0xFFC");

    io_read(5'h14, 2'd2, pat(12'hFFC), "R4 data read word");
    io_read(5'h14, 2'd0, pat(12'hFFC), "R4 data read byte");
    io_write(5'h14, 2'd0, 32'hCAFE_F00D, 12'hFFC);
    io_write(5'h14, 2'd1, 32'h0102_0304, 12'hFFC);
    io_read(5'h10, 2'd2, 32'hFFC, "R8 index unchanged by data access");

    io_write(5'h10, 2'd2, 32'h48, 12'hFFC);
    io_read(5'h10, 2'd2, 32'h48, "R3 back-to-back index read");
    io_read(5'h14, 2'd2, pat(12'h048), "R4 back-to-back data read");

    io_read(5'h11, 2'd0, 32'h0, "R6 unaligned 0x11 reads zero");
    io_read(5'h00, 2'd2, 32'h0, "R6 offset 0x00 reads zero");
    io_read(5'h1F, 2'd0, 32'h0, "R6 offset 0x1F reads zero");
    io_read(5'h15, 2'd0, 32'h0, "R6 unaligned 0x15 reads zero");

    io_write(5'h00, 2'd2, 32'h0000_0100, 12'h048);
    io_write(5'h12, 2'd1, 32'h0000_0200, 12'h048);
    io_write(5'h17, 2'd0, 32'h0000_0300, 12'h048);
    io_read(5'h10, 2'd2, 32'h48, "R7 index unchanged by unused writes");

    io_read(5'h14, 2'd2, pat(12'h048), "R9 value before hold");
    repeat (3) @(negedge clk);
    check(io_rdata === pat(12'h048), "R9 rdata held without read",
          io_rdata, pat(12'h048));

    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "scoreboard drained", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule